// File: doc/BRIEF.md
# Polled SPI Master with Register Interface

This block is an SPI bus master that software drives through a small bank of 32-bit registers. Software programs clock polarity, clock phase and a two-stage bit-rate divider, asserts the single chip select by writing a register bit, and writes one byte to the transmit register. That write starts one full-duplex 8-bit exchange. While the byte goes out on the data-out pin, the byte coming back on the data-in pin is shifted in.

The block raises no interrupts. Software polls a status register. One flag shows that the engine is busy, and a second shows that a received byte is waiting. Reading the receive register takes the byte and clears the waiting flag. If the byte is left unread, the next exchange overwrites it.

Inside the block, a register bank feeds a four-state engine (IDLE, LEAD, TRAIL, DONE) and a half-period tick counter. The transitions are:
- IDLE → LEAD when a transmit write arrives.
- LEAD → TRAIL on a tick, which is the leading SCLK edge.
- TRAIL → LEAD on a tick, which is the trailing edge, while bits remain.
- TRAIL → DONE on the trailing edge of the eighth bit.
- DONE → IDLE unconditionally. DONE commits the received byte.

Top module: `regspi_master`

## Requirements
- R1: After reset, cs_n is 1 and sclk is 0. Word 0x00 (control), word 0x04 (status) and word 0x14 (auxiliary) read 0. Word 0x08 (select control) reads 0x40.
- R2: Let P be 128 when control bit 5 is set and 16 when it is clear, and let N be control bits [4:0]. One SCLK half period then lasts P*(N+1) clock cycles, and status bit 0 stays 1 for exactly 16*P*(N+1)+1 cycles after the clock edge that accepts the transmit write.
- R3: While no exchange runs, sclk rests at control bit 6 (CPOL).
- R4: A write to word 0x0C while idle starts an exchange of its low 8 bits, and status bit 0 reads 1 from the next cycle until the exchange ends.
- R5: Both directions are MSB first. With control bit 7 (CPHA) clear, data-in is sampled on leading edges and data-out changes on trailing edges. With CPHA set, data-out changes on leading edges after the first, and data-in is sampled on trailing edges.
- R6: When an exchange ends, status bit 2 becomes 1 and word 0x10 bits [7:0] hold the received byte.
- R7: A read of word 0x10 clears status bit 2. A write to word 0x04 with bit 2 at 0 also clears it.
- R8: An exchange that ends while status bit 2 is still 1 replaces the held byte, and the flag stays 1.
- R9: A write to word 0x0C while status bit 0 is 1 is ignored. The running exchange keeps its byte and its length, and no second exchange follows.
- R10: cs_n follows bit 6 of word 0x08 (0 selects). Bits [7:0] of that word read back as written; the value 0x21 selects master mode with software-driven select.
- R11: Bits [7:0] of word 0x00 and of word 0x14 read back as written. Word 0x14 has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (for read side effects) |
| addr | input | 5 | Byte address of the register word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
The assertions take for granted that at most one of wr_en and rd_en is high in any cycle. They also assume that miso settles only between the engine's sampling edges, since a level that changes at a sampling tick would make the received byte arbitrary.

The bench drives each bus access on the falling clock edge as a single-cycle strobe, never raising both strobes together. Its slave model updates miso only on the SCLK edge opposite the sampling edge.

Control values are kept to small divisors, so every exchange stays a few thousand cycles long. Control is rewritten only while the select is released, so a polarity change never reaches the slave model as a clock edge.

// File: rtl/regspi_pkg.sv
package regspi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2,
        ST_DONE  = 2'd3
    } eng_state_t;

    // word indices (byte address >> 2)
    localparam logic [2:0] W_CTRL = 3'd0;
    localparam logic [2:0] W_STAT = 3'd1;
    localparam logic [2:0] W_SEL  = 3'd2;
    localparam logic [2:0] W_TX   = 3'd3;
    localparam logic [2:0] W_RX   = 3'd4;
    localparam logic [2:0] W_AUX  = 3'd5;

    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_FULL_BIT = 2;
    localparam int SEL_CS_BIT    = 6;
    localparam logic [7:0] SEL_RESET = 8'h40;

endpackage

// File: rtl/regspi_clkdiv.sv
module regspi_clkdiv #(
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 128,
    parameter int DIV_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             pre_sel,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);
    localparam int MAX_HALF = PRE_HI * (2 ** DIV_W);
    localparam int CNT_W    = $clog2(MAX_HALF) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_len;
    logic [CNT_W-1:0] pre_val;

    always_comb begin
        pre_val  = pre_sel ? CNT_W'(PRE_HI) : CNT_W'(PRE_LO);
        half_len = CNT_W'(pre_val * (CNT_W'(div_n) + CNT_W'(1)));
    end

    assign tick = run && (cnt_q == half_len - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R2: a half period is never shorter than two cycles
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/regspi_engine.sv
module regspi_engine
    import regspi_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              pre_sel,
    input  logic [DIV_W-1:0]  div_n,
    input  logic              tick,
    input  logic              miso,
    output logic              run,
    output logic              pre_q,
    output logic [DIV_W-1:0]  div_q,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_data,
    output logic              sclk,
    output logic              mosi
);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    eng_state_t state_q, state_d;

    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic [BIT_W-1:0]  bit_q;
    logic              cpol_q;
    logic              cpha_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LEAD;
            ST_LEAD:  if (tick)  state_d = ST_TRAIL;
            ST_TRAIL: if (tick)  state_d = (bit_q == LAST_BIT) ? ST_DONE : ST_LEAD;
            ST_DONE:             state_d = ST_IDLE;
            default:             state_d = ST_IDLE;
        endcase
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh  <= '0;
            rx_sh  <= '0;
            bit_q  <= '0;
            cpol_q <= 1'b0;
            cpha_q <= 1'b0;
            pre_q  <= 1'b0;
            div_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        tx_sh  <= tx_byte;
                        bit_q  <= '0;
                        cpol_q <= cpol;
                        cpha_q <= cpha;
                        pre_q  <= pre_sel;
                        div_q  <= div_n;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        if (!cpha_q)
                            rx_sh <= {rx_sh[DATA_W-2:0], miso};
                        else if (bit_q != '0)
                            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        if (cpha_q)
                            rx_sh <= {rx_sh[DATA_W-2:0], miso};
                        else
                            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                        if (bit_q != LAST_BIT)
                            bit_q <= bit_q + BIT_W'(1);
                    end
                end
                ST_DONE: begin
                    bit_q <= '0;
                end
                default: ;
            endcase
        end
    end

    assign run     = (state_q == ST_LEAD) || (state_q == ST_TRAIL);
    assign busy    = (state_q != ST_IDLE);
    assign done    = (state_q == ST_DONE);
    assign rx_data = rx_sh;
    assign mosi    = tx_sh[DATA_W-1];
    assign sclk    = (state_q == ST_TRAIL) ? ~cpol_q :
                     (state_q == ST_IDLE)  ? cpol : cpol_q;

    // R5: data-out moves only on an SCLK edge
    a_r5_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(mosi));

    // R4: an accepted start always leaves idle
    a_r4_start_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

endmodule

// File: rtl/regspi_master.sv
module regspi_master
    import regspi_pkg::*;
#(
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 128,
    parameter int DIV_W  = 5,
    parameter int DATA_W = 8,
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    localparam int REG_W = 8;

    logic [REG_W-1:0]  ctrl_q;
    logic [REG_W-1:0]  sel_q;
    logic [REG_W-1:0]  aux_q;
    logic [DATA_W-1:0] rxbuf_q;
    logic              full_q;

    logic [2:0]        widx;
    logic              wr_ctrl, wr_stat, wr_sel, wr_tx, wr_aux, rd_rx;
    logic              start;
    logic              run, tick, busy, done, pre_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] rx_data;

    assign widx    = addr[4:2];
    assign wr_ctrl = wr_en && (widx == W_CTRL);
    assign wr_stat = wr_en && (widx == W_STAT);
    assign wr_sel  = wr_en && (widx == W_SEL);
    assign wr_tx   = wr_en && (widx == W_TX);
    assign wr_aux  = wr_en && (widx == W_AUX);
    assign rd_rx   = rd_en && (widx == W_RX);
    assign start   = wr_tx && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            sel_q   <= SEL_RESET;
            aux_q   <= '0;
            rxbuf_q <= '0;
            full_q  <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata[REG_W-1:0];
            if (wr_sel)  sel_q  <= wdata[REG_W-1:0];
            if (wr_aux)  aux_q  <= wdata[REG_W-1:0];
            if (done) begin
                rxbuf_q <= rx_data;
                full_q  <= 1'b1;
            end else if (rd_rx || (wr_stat && !wdata[STAT_FULL_BIT])) begin
                full_q  <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (widx)
            W_CTRL:  rdata[REG_W-1:0] = ctrl_q;
            W_STAT: begin
                rdata[STAT_BUSY_BIT] = busy;
                rdata[STAT_FULL_BIT] = full_q;
            end
            W_SEL:   rdata[REG_W-1:0]  = sel_q;
            W_RX:    rdata[DATA_W-1:0] = rxbuf_q;
            W_AUX:   rdata[REG_W-1:0]  = aux_q;
            default: rdata = '0;
        endcase
    end

    assign cs_n = sel_q[SEL_CS_BIT];

    regspi_clkdiv #(
        .PRE_LO(PRE_LO),
        .PRE_HI(PRE_HI),
        .DIV_W (DIV_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .pre_sel(pre_q),
        .div_n  (div_q),
        .tick   (tick)
    );

    regspi_engine #(
        .DATA_W(DATA_W),
        .DIV_W (DIV_W)
    ) u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .tx_byte(wdata[DATA_W-1:0]),
        .cpol   (ctrl_q[6]),
        .cpha   (ctrl_q[7]),
        .pre_sel(ctrl_q[5]),
        .div_n  (ctrl_q[DIV_W-1:0]),
        .tick   (tick),
        .miso   (miso),
        .run    (run),
        .pre_q  (pre_q),
        .div_q  (div_q),
        .busy   (busy),
        .done   (done),
        .rx_data(rx_data),
        .sclk   (sclk),
        .mosi   (mosi)
    );

    // R4: a transmit write while idle makes the engine busy next cycle
    a_r4_busy_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && !busy) |=> busy);

    // R6: end of exchange raises the receive flag
    a_r6_full_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> full_q);

    // R7: reading the receive word drops the flag unless a byte lands
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && !done) |=> !full_q);

    // R3: clock rests at the programmed polarity when idle
    a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == ctrl_q[6]));

    // R9: a transmit write during an exchange does not restart it
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && busy && !done) |=> busy);

endmodule

// File: tb/sim_regspi_master.sv
module sim_regspi_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sclk, mosi, miso, cs_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk; // 125 MHz

    regspi_master u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    // slave model
    logic [7:0] s_tx = '0;
    logic [7:0] s_rx = '0;
    int         s_lead = 0;
    logic       b_cpol = 1'b0;
    logic       b_cpha = 1'b0;

    assign miso = s_tx[7];

    always @(sclk) begin
        if (cs_n === 1'b0) begin
            if (sclk != b_cpol) begin
                if (!b_cpha) s_rx = {s_rx[6:0], mosi};
                else if (s_lead != 0) s_tx = {s_tx[6:0], 1'b0};
                s_lead++;
            end else begin
                if (b_cpha) s_rx = {s_rx[6:0], mosi};
                else s_tx = {s_tx[6:0], 1'b0};
            end
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic side, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = side;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic slave_load(input logic [7:0] b);
        s_tx = b; s_rx = '0; s_lead = 0;
    endtask

    // count cycles with busy set, starting at the negedge after the write
    task automatic wait_idle(output int n);
        n = 0;
        addr = 5'h04;
        #1;
        while (rdata[0] === 1'b1 && n < 100000) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    function automatic int exp_busy(input logic [7:0] c);
        int p;
        p = c[5] ? 128 : 16;
        return 16 * p * (int'(c[4:0]) + 1) + 1;
    endfunction

    // {ctrl, tx byte, slave byte}
    localparam int NV = 6;
    localparam logic [23:0] VEC [NV] = '{
        24'h00_A5_3C,
        24'h41_81_7E,
        24'h80_5A_C3,
        24'hC2_0F_F0,
        24'h20_96_69,
        24'h03_FF_00
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        int n;
        repeat (3) @(negedge clk);
        // R1 reset values
        check(cs_n === 1'b1, "R1 cs_n", cs_n, 1);
        check(sclk === 1'b0, "R1 sclk", sclk, 0);
        rd(5'h00, 1'b0, d); check(d == 0, "R1 ctrl", d, 0);
        rd(5'h04, 1'b0, d); check(d == 0, "R1 status", d, 0);
        rd(5'h08, 1'b0, d); check(d == 32'h40, "R1 sel", d, 32'h40);
        rd(5'h14, 1'b0, d); check(d == 0, "R1 aux", d, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [7:0] c, t, s;
            {c, t, s} = VEC[i];
            wr(5'h00, {24'h0, c});
            b_cpol = c[6]; b_cpha = c[7];
            rd(5'h00, 1'b0, d); check(d == {24'h0, c}, "R11 ctrl readback", d, c);
            check(sclk === c[6], "R3 idle level", sclk, c[6]);
            wr(5'h08, 32'h21);
            check(cs_n === 1'b0, "R10 select", cs_n, 0);
            slave_load(s);
            wr(5'h0C, {24'h0, t});
            wait_idle(n);
            check(n == exp_busy(c), "R2 R4 busy length", n, exp_busy(c));
            check(s_rx == t, "R5 slave captured", s_rx, t);
            rd(5'h04, 1'b0, d); check(d == 32'h4, "R6 flag set", d, 4);
            rd(5'h10, 1'b1, d); check(d == {24'h0, s}, "R5 R6 rx byte", d, s);
            rd(5'h04, 1'b0, d); check(d == 0, "R7 read clears", d, 0);
            check(sclk === c[6], "R3 level after", sclk, c[6]);
            wr(5'h08, 32'h61);
            check(cs_n === 1'b1, "R10 release", cs_n, 1);
        end

        // R8: overwrite without read; R7: status write clears
        wr(5'h00, 32'h00); b_cpol = 0; b_cpha = 0;
        wr(5'h08, 32'h21);
        slave_load(8'h11); wr(5'h0C, 32'h22); wait_idle(n);
        slave_load(8'h33); wr(5'h0C, 32'h44); wait_idle(n);
        rd(5'h04, 1'b0, d); check(d == 32'h4, "R8 flag still set", d, 4);
        rd(5'h10, 1'b0, d); check(d == 32'h33, "R8 newest byte", d, 32'h33);
        wr(5'h04, 32'h0);
        rd(5'h04, 1'b0, d); check(d == 0, "R7 status write clears", d, 0);

        // R9: write during exchange ignored
        slave_load(8'hE7); wr(5'h0C, 32'h3C);
        repeat (40) @(negedge clk);
        wr(5'h0C, 32'hC3);
        wait_idle(n);
        check(n == exp_busy(8'h00) - 42, "R9 length kept", n, exp_busy(8'h00) - 42);
        check(s_rx == 8'h3C, "R9 first byte sent", s_rx, 32'h3C);
        repeat (10) @(negedge clk);
        rd(5'h04, 1'b0, d); check(d == 32'h4, "R9 no second exchange", d, 4);
        rd(5'h10, 1'b1, d); check(d == 32'hE7, "R9 rx byte", d, 32'hE7);

        // R10/R11 readbacks
        rd(5'h08, 1'b0, d); check(d == 32'h21, "R10 sel readback", d, 32'h21);
        wr(5'h14, 32'hFFFF_FF5A);
        rd(5'h14, 1'b0, d); check(d == 32'h5A, "R11 aux readback", d, 32'h5A);
        rd(5'h04, 1'b0, d); check(d == 0, "R11 aux no effect", d, 0);
        wr(5'h08, 32'h61);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule